// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This combinational unit forms the second source operand of a 32-bit data-processing datapath. It also forms the shifter carry that flag logic uses. In register mode it shifts or rotates a register value. The amount comes either from a 5-bit field in the instruction or from the low byte of a second register. A special code gives a one-place rotate through the incoming carry flag. In immediate mode it builds a 32-bit constant by rotating an 8-bit value right by an even amount.

The unit drives its outputs in the same cycle as its inputs. It holds no state. Register read, the ALU, the flag register and full instruction decode all sit outside it. The surrounding decoder supplies only the operand-select fields.

Top module: `op2_shifter`

## Requirements
- R1: With `shift_kind`=00 (shift left) and an amount n from 1 to 31, `opnd_out` is `src_val` shifted left by n with zeros entering the low bits. `carry_out` is `src_val[32-n]`.
- R2: With `shift_kind`=01 (logical shift right) and n from 1 to 31, `opnd_out` is `src_val` shifted right by n with zeros entering the high bits. `carry_out` is `src_val[n-1]`.
- R3: With `shift_kind`=10 (arithmetic shift right) and n from 1 to 31, the n high bits of `opnd_out` are copies of `src_val[31]`. `carry_out` is `src_val[n-1]`.
- R4: With `shift_kind`=11 (rotate right) and n from 1 to 31, `opnd_out` is `src_val` rotated right by n. `carry_out` equals `opnd_out[31]`.
- R5: With the amount taken from `imm_amt` (`amt_from_reg`=0), `shift_kind`=11 and `imm_amt`=0, the result is a one-place rotate through the carry. `opnd_out` is {`carry_in`, `src_val[31:1]`} and `carry_out` is `src_val[0]`.
- R6: With the amount taken from `imm_amt`, an `imm_amt` of 0 means an amount of 32 for kinds 01 and 10. For kind 00 it passes `src_val` through with `carry_out`=`carry_in`.
- R7: When the amount comes from `amt_reg` (`amt_from_reg`=1), only `amt_reg[7:0]` is used. Bits 31:8 have no effect on either output.
- R8: A register amount of 0 passes `src_val` to `opnd_out` with `carry_out`=`carry_in`, for every kind.
- R9: A register amount of exactly 32 gives zero for kinds 00 and 01. The carry is then `src_val[0]` for kind 00 and `src_val[31]` for kind 01. An amount above 32 gives zero with carry 0.
- R10: A register amount of 32 or more with kind 10 sets every bit of `opnd_out`, and `carry_out`, to `src_val[31]`.
- R11: A register rotate uses the amount modulo 32. A nonzero multiple of 32 leaves `src_val` unchanged with `carry_out`=`src_val[31]`.
- R12: With `opnd_sel_imm`=1, `opnd_out` is `imm_byte` zero-extended and rotated right by 2×`imm_rot`. `carry_out` is `carry_in` when `imm_rot`=0, and `opnd_out[31]` otherwise. The shift inputs have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_sel_imm | input | 1 | 1 selects the rotated-immediate form |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_reg`, 0 from `imm_amt` |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| imm_amt | input | 5 | Amount field from the instruction |
| amt_reg | input | 32 | Register holding the amount (low byte used) |
| src_val | input | 32 | Register value to shift |
| imm_byte | input | 8 | 8-bit immediate constant |
| imm_rot | input | 4 | Rotate field, counted in pairs of bits |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench aims at the amount boundaries where shifters usually go wrong. These are register amounts of 0, 31, 32, 33, 64 and 255, and instruction amounts of 0, which change meaning by kind. A design that clamped amounts to five bits would rotate or keep bits where zero or sign fill is required. A design that read all 32 bits of the amount register would give zero where a small shift is expected. A carry taken from the wrong end would show at amounts 1 and 32. A rotate-through-carry that skipped the incoming flag would leave bit 31 wrong. The immediate form is checked with rotate 0 against nonzero rotates, since only the former keeps the carry.

// File: rtl/bsh_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the second-operand shifter.
// Assumes a two-bit shift kind code fixed by the instruction decoder.
package bsh_pkg;
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/bsh_imm_expand.sv
`timescale 1ns/1ps
// Expands an 8-bit constant into a full-width operand by an even right rotate.
// Assumes the rotate field counts bit pairs; carry passes through on rotate zero.
module bsh_imm_expand #(
    parameter int W     = 32,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic [IMM_W-1:0] imm_byte,
    input  logic [ROT_W-1:0] imm_rot,
    input  logic             carry_in,
    output logic [W-1:0]     value,
    output logic             carry_out
);
    localparam int RA_W = ROT_W + 1;

    logic [W-1:0]    zext;
    logic [RA_W-1:0] rot_amt;

    // Rotate the zero-extended byte right by twice the rotate field.
    always_comb begin
        zext      = W'(imm_byte);
        rot_amt   = {imm_rot, 1'b0};
        value     = (zext >> rot_amt) | (zext << (W - int'(rot_amt)));
        carry_out = (imm_rot == '0) ? carry_in : value[W-1];
    end
endmodule

// File: rtl/bsh_amt_decode.sv
`timescale 1ns/1ps
// Turns the amount source into an effective amount and a rotate-extend flag.
// Assumes instruction amount 0 encodes 32 for right shifts and rotate-extend for rotate.
module bsh_amt_decode
    import bsh_pkg::*;
#(
    parameter int W         = 32,
    parameter int SH_W      = 5,
    parameter int AMT_SRC_W = 8
) (
    input  logic                 from_reg,
    input  shift_kind_e          kind,
    input  logic [SH_W-1:0]      imm_amt,
    input  logic [AMT_SRC_W-1:0] reg_amt,
    output logic [AMT_SRC_W-1:0] eff_amt,
    output logic                 rrx
);
    // Select the amount source and apply the instruction-field zero encodings.
    always_comb begin
        rrx     = 1'b0;
        eff_amt = AMT_SRC_W'(imm_amt);
        if (from_reg) begin
            eff_amt = reg_amt;
        end else if (imm_amt == '0) begin
            case (kind)
                SK_LSR, SK_ASR: eff_amt = AMT_SRC_W'(W);
                SK_ROR:         rrx     = 1'b1;
                default:        eff_amt = '0;
            endcase
        end
    end
endmodule

// File: rtl/bsh_shift_core.sv
`timescale 1ns/1ps
// Barrel shift or rotate by an effective amount with carry-out tracking.
// Assumes amounts up to 2**AMT_SRC_W-1; shifts past the width fill or clear naturally.
module bsh_shift_core
    import bsh_pkg::*;
#(
    parameter int W         = 32,
    parameter int SH_W      = 5,
    parameter int AMT_SRC_W = 8
) (
    input  logic [W-1:0]         val,
    input  shift_kind_e          kind,
    input  logic [AMT_SRC_W-1:0] amt,
    input  logic                 rrx,
    input  logic                 carry_in,
    output logic [W-1:0]         res,
    output logic                 carry_out
);
    logic [W:0]        lsl_t;
    logic [W:0]        lsr_t;
    logic signed [W:0] asr_t;
    logic [SH_W-1:0]   rot;
    logic [W-1:0]      ror_v;

    // Widened shifts keep the last bit shifted out beside the result.
    always_comb begin
        lsl_t = {1'b0, val} << amt;
        lsr_t = {val, 1'b0} >> amt;
        asr_t = $signed({val, 1'b0}) >>> amt;
        rot   = amt[SH_W-1:0];
        ror_v = (val >> rot) | (val << (W - int'(rot)));
    end

    // Pick the result for the requested kind and the zero/extend specials.
    always_comb begin
        res       = val;
        carry_out = carry_in;
        if (rrx) begin
            res       = {carry_in, val[W-1:1]};
            carry_out = val[0];
        end else if (amt != '0) begin
            case (kind)
                SK_LSL: begin res = lsl_t[W-1:0]; carry_out = lsl_t[W]; end
                SK_LSR: begin res = lsr_t[W:1];   carry_out = lsr_t[0]; end
                SK_ASR: begin res = asr_t[W:1];   carry_out = asr_t[0]; end
                default: begin res = ror_v;       carry_out = ror_v[W-1]; end
            endcase
        end
    end
endmodule

// File: rtl/op2_shifter.sv
`timescale 1ns/1ps
// Second-operand unit: shifted register or rotated immediate, plus shifter carry.
// Purely combinational; assumes fields arrive already split out by the decoder.
module op2_shifter
    import bsh_pkg::*;
#(
    parameter int W         = 32,
    parameter int AMT_SRC_W = 8,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4
) (
    input  logic             opnd_sel_imm,
    input  logic             amt_from_reg,
    input  logic [1:0]       shift_kind,
    input  logic [4:0]       imm_amt,
    input  logic [W-1:0]     amt_reg,
    input  logic [W-1:0]     src_val,
    input  logic [IMM_W-1:0] imm_byte,
    input  logic [ROT_W-1:0] imm_rot,
    input  logic             carry_in,
    output logic [W-1:0]     opnd_out,
    output logic             carry_out
);
    localparam int SH_W = $clog2(W);

    shift_kind_e          kind;
    logic [AMT_SRC_W-1:0] eff_amt;
    logic                 rrx;
    logic [W-1:0]         sh_res;
    logic                 sh_c;
    logic [W-1:0]         im_res;
    logic                 im_c;
    logic                 unused_amt_hi;

    assign kind          = shift_kind_e'(shift_kind);
    assign unused_amt_hi = ^amt_reg[W-1:AMT_SRC_W];

    bsh_amt_decode #(.W(W), .SH_W(SH_W), .AMT_SRC_W(AMT_SRC_W)) u_amt (
        .from_reg (amt_from_reg),
        .kind     (kind),
        .imm_amt  (imm_amt[SH_W-1:0]),
        .reg_amt  (amt_reg[AMT_SRC_W-1:0]),
        .eff_amt  (eff_amt),
        .rrx      (rrx)
    );

    bsh_shift_core #(.W(W), .SH_W(SH_W), .AMT_SRC_W(AMT_SRC_W)) u_core (
        .val       (src_val),
        .kind      (kind),
        .amt       (eff_amt),
        .rrx       (rrx),
        .carry_in  (carry_in),
        .res       (sh_res),
        .carry_out (sh_c)
    );

    bsh_imm_expand #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
        .imm_byte  (imm_byte),
        .imm_rot   (imm_rot),
        .carry_in  (carry_in),
        .value     (im_res),
        .carry_out (im_c)
    );

    // Choose between the immediate and shifted-register forms.
    always_comb begin
        opnd_out  = opnd_sel_imm ? im_res : sh_res;
        carry_out = opnd_sel_imm ? im_c   : sh_c;
    end
endmodule

// File: rtl/op2_shifter_chk.sv
`timescale 1ns/1ps
// Port-level checks for op2_shifter, bound onto every instance.
// Assumes the default 32-bit width and 8-bit amount byte.
module op2_shifter_chk (
    input logic        opnd_sel_imm,
    input logic        amt_from_reg,
    input logic [1:0]  shift_kind,
    input logic [4:0]  imm_amt,
    input logic [31:0] amt_reg,
    input logic [31:0] src_val,
    input logic [7:0]  imm_byte,
    input logic [3:0]  imm_rot,
    input logic        carry_in,
    input logic [31:0] opnd_out,
    input logic        carry_out
);
    logic [31:0] low_mask;

    // Mask of the bits a left shift by the register amount must clear.
    always_comb low_mask = (32'h1 << amt_reg[7:0]) - 32'h1;

    // Immediate output relations against the input ports.
    always_comb begin
        if (opnd_sel_imm && imm_rot == 4'd0)
            a_r12_imm_norot: assert (opnd_out == {24'h0, imm_byte} && carry_out == carry_in)
                else $error("R12 immediate without rotate");
        if (!opnd_sel_imm && amt_from_reg && amt_reg[7:0] == 8'd0)
            a_r8_zero_pass: assert (opnd_out == src_val && carry_out == carry_in)
                else $error("R8 zero amount pass-through");
        if (!opnd_sel_imm && !amt_from_reg && shift_kind == 2'b11 && imm_amt == 5'd0)
            a_r5_rrx: assert (opnd_out[31] == carry_in && carry_out == src_val[0]
                              && opnd_out[30:0] == src_val[31:1])
                else $error("R5 rotate through carry");
        if (!opnd_sel_imm && amt_from_reg && shift_kind == 2'b10 && amt_reg[7:0] >= 8'd32)
            a_r10_sign_fill: assert (opnd_out == {32{src_val[31]}} && carry_out == src_val[31])
                else $error("R10 sign fill");
        if (!opnd_sel_imm && amt_from_reg && shift_kind == 2'b00
            && amt_reg[7:0] != 8'd0 && amt_reg[7:0] < 8'd32)
            a_r1_low_zero: assert ((opnd_out & low_mask) == 32'h0)
                else $error("R1 low bits not cleared");
        if (!opnd_sel_imm && amt_from_reg && shift_kind[1] == 1'b0 && amt_reg[7:0] > 8'd32)
            a_r9_past_width: assert (opnd_out == 32'h0 && carry_out == 1'b0)
                else $error("R9 logical shift past width");
    end
endmodule

bind op2_shifter op2_shifter_chk i_chk (
    .opnd_sel_imm (opnd_sel_imm),
    .amt_from_reg (amt_from_reg),
    .shift_kind   (shift_kind),
    .imm_amt      (imm_amt),
    .amt_reg      (amt_reg),
    .src_val      (src_val),
    .imm_byte     (imm_byte),
    .imm_rot      (imm_rot),
    .carry_in     (carry_in),
    .opnd_out     (opnd_out),
    .carry_out    (carry_out)
);

// File: tb/test_op2_shifter.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random vectors.
module test_op2_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        opnd_sel_imm, amt_from_reg, carry_in;
    logic [1:0]  shift_kind;
    logic [4:0]  imm_amt;
    logic [31:0] amt_reg, src_val;
    logic [7:0]  imm_byte;
    logic [3:0]  imm_rot;
    logic [31:0] opnd_out;
    logic        carry_out;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    op2_shifter i_op2_shifter (
        .opnd_sel_imm (opnd_sel_imm),
        .amt_from_reg (amt_from_reg),
        .shift_kind   (shift_kind),
        .imm_amt      (imm_amt),
        .amt_reg      (amt_reg),
        .src_val      (src_val),
        .imm_byte     (imm_byte),
        .imm_rot      (imm_rot),
        .carry_in     (carry_in),
        .opnd_out     (opnd_out),
        .carry_out    (carry_out)
    );

    // Reference built from single-step moves, following the requirements.
    function automatic logic [32:0] ref_op(input logic sel, input logic frm,
            input logic [1:0] k, input logic [4:0] ia, input logic [31:0] ra,
            input logic [31:0] s, input logic [7:0] b, input logic [3:0] r, input logic ci);
        logic [31:0] v;
        logic        c;
        int          n;
        c = ci;
        if (sel) begin
            v = {24'h0, b};
            for (int i = 0; i < 2 * int'(r); i++) v = {v[0], v[31:1]};
            if (r != 0) c = v[31];
            return {c, v};
        end
        v = s;
        n = frm ? int'(ra[7:0]) : int'(ia);
        if (!frm && n == 0) begin
            if (k == 2'b11) return {s[0], ci, s[31:1]};
            if (k != 2'b00) n = 32;
        end
        if (n == 0) return {ci, s};
        case (k)
            2'b00: for (int i = 0; i < n; i++) begin c = v[31]; v = v << 1; end
            2'b01: for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end
            2'b10: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
            default: begin
                if (n % 32 == 0) c = v[31];
                else for (int i = 0; i < n % 32; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
            end
        endcase
        return {c, v};
    endfunction

    // Requirement tag for a vector, used in random-phase messages.
    function automatic string tag_of();
        int n;
        n = int'(amt_reg[7:0]);
        if (opnd_sel_imm) return "R12";
        if (!amt_from_reg) begin
            if (imm_amt == 0) return (shift_kind == 2'b11) ? "R5" : "R6";
        end else begin
            if (amt_reg[31:8] != 0) return "R7";
            if (n == 0) return "R8";
            if (n >= 32) begin
                if (shift_kind == 2'b10) return "R10";
                if (shift_kind == 2'b11) return "R11";
                return "R9";
            end
        end
        case (shift_kind)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Drive one vector on the falling edge, then compare mid-phase.
    task automatic apply(input string req, input logic sel, input logic frm,
            input logic [1:0] k, input logic [4:0] ia, input logic [31:0] ra,
            input logic [31:0] s, input logic [7:0] b, input logic [3:0] r, input logic ci);
        logic [32:0] exp;
        string       t;
        @(negedge clk);
        opnd_sel_imm = sel; amt_from_reg = frm; shift_kind = k; imm_amt = ia;
        amt_reg = ra; src_val = s; imm_byte = b; imm_rot = r; carry_in = ci;
        #2;
        exp = ref_op(sel, frm, k, ia, ra, s, b, r, ci);
        t = (req == "") ? tag_of() : req;
        n_vec++;
        if ({carry_out, opnd_out} !== exp) begin
            n_bad++;
            $display("FAIL %s: got c=%b v=%h, expected c=%b v=%h", t,
                     carry_out, opnd_out, exp[32], exp[31:0]);
        end
    endtask

    // Watchdog: a hung run counts as one miscompare.
    initial begin
        #1600000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        opnd_sel_imm = 0; amt_from_reg = 0; shift_kind = 0; imm_amt = 0;
        amt_reg = 0; src_val = 0; imm_byte = 0; imm_rot = 0; carry_in = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: instruction-field left shift by 0 passes zero through (R6).
        apply("R6", 0, 0, 2'b00, 5'd0, 0, 32'h0, 0, 0, 0);
        // R1 shift left, carry from the last bit out.
        apply("R1", 0, 0, 2'b00, 5'd1, 0, 32'h8000_0001, 0, 0, 0);
        apply("R1", 0, 1, 2'b00, 5'd0, 32'd31, 32'h0000_0003, 0, 0, 0);
        // R2 logical right.
        apply("R2", 0, 0, 2'b01, 5'd4, 0, 32'hF000_0018, 0, 0, 1);
        // R3 arithmetic right on a negative value.
        apply("R3", 0, 0, 2'b10, 5'd8, 0, 32'h8000_0080, 0, 0, 0);
        // R4 rotate right.
        apply("R4", 0, 0, 2'b11, 5'd1, 0, 32'h0000_0001, 0, 0, 0);
        apply("R4", 0, 1, 2'b11, 5'd0, 32'd16, 32'h1234_5678, 0, 0, 0);
        // R5 rotate through carry with both carry values.
        apply("R5", 0, 0, 2'b11, 5'd0, 0, 32'h0000_0001, 0, 0, 1);
        apply("R5", 0, 0, 2'b11, 5'd0, 0, 32'hFFFF_FFFE, 0, 0, 0);
        // R6 instruction amount 0 means 32 for right shifts.
        apply("R6", 0, 0, 2'b01, 5'd0, 0, 32'h8000_0000, 0, 0, 0);
        apply("R6", 0, 0, 2'b10, 5'd0, 0, 32'h8000_0000, 0, 0, 0);
        apply("R6", 0, 0, 2'b00, 5'd0, 0, 32'hDEAD_BEEF, 0, 0, 1);
        // R7 upper amount bits ignored.
        apply("R7", 0, 1, 2'b00, 5'd0, 32'hFFFF_FF04, 32'h0000_00FF, 0, 0, 0);
        apply("R7", 0, 1, 2'b01, 5'd0, 32'h0100_0000, 32'h1234_5678, 0, 0, 1);
        // R8 zero register amount for every kind.
        for (int k = 0; k < 4; k++)
            apply("R8", 0, 1, 2'(k), 5'd9, 32'h0, 32'hA5A5_0F0F, 0, 0, 1);
        // R9 logical shifts at and past the width.
        apply("R9", 0, 1, 2'b00, 5'd0, 32'd32, 32'h0000_0001, 0, 0, 0);
        apply("R9", 0, 1, 2'b01, 5'd0, 32'd32, 32'h8000_0000, 0, 0, 0);
        apply("R9", 0, 1, 2'b00, 5'd0, 32'd33, 32'hFFFF_FFFF, 0, 0, 1);
        apply("R9", 0, 1, 2'b01, 5'd0, 32'd255, 32'hFFFF_FFFF, 0, 0, 1);
        // R10 arithmetic at and past the width.
        apply("R10", 0, 1, 2'b10, 5'd0, 32'd32, 32'h8000_0000, 0, 0, 0);
        apply("R10", 0, 1, 2'b10, 5'd0, 32'd200, 32'h7FFF_FFFF, 0, 0, 1);
        // R11 rotate modulo the width.
        apply("R11", 0, 1, 2'b11, 5'd0, 32'd32, 32'h8000_0001, 0, 0, 0);
        apply("R11", 0, 1, 2'b11, 5'd0, 32'd64, 32'h0000_0001, 0, 0, 1);
        apply("R11", 0, 1, 2'b11, 5'd0, 32'd36, 32'h0000_00F0, 0, 0, 0);
        // R12 immediate form, with shift inputs set to busy values.
        apply("R12", 1, 1, 2'b01, 5'd7, 32'd3, 32'hFFFF_FFFF, 8'hAB, 4'd0, 1);
        apply("R12", 1, 0, 2'b11, 5'd0, 32'd0, 32'h1234_5678, 8'h81, 4'd1, 0);
        apply("R12", 1, 0, 2'b00, 5'd3, 32'd0, 32'h0, 8'hFF, 4'd15, 0);
        // Seeded random phase.
        void'($urandom(32'h0C0FFEE5));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra;
            ra = $urandom();
            if ($urandom_range(3) != 0) ra = (ra & 32'h0000_00FF) % 70;
            if ($urandom_range(7) == 0) ra = ra | 32'h0000_0100;
            apply("", $urandom_range(5) == 0, 1'($urandom()), 2'($urandom()),
                  ($urandom_range(4) == 0) ? 5'd0 : 5'($urandom()), ra,
                  $urandom(), 8'($urandom()), 4'($urandom()), 1'($urandom()));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule